// File: doc/BRIEF.md
# Modulo-UI Phase Tracking Filter

This block smooths a stream of per-UI zero-crossing phase estimates into one average crossing phase. On every clock it takes a word of several lane estimates, each with its own valid flag. It forms the wrapped error of each valid lane against the current average and adds those errors into one sum. The sum then drives a chain of saturating integrators whose gains are set by shifts. The registered average follows both static phase offsets and frequency offsets between transmitter and receiver.

Phase is an unsigned fixed-point fraction of one UI. Subtracting two phases therefore wraps the way the circle of a UI wraps. The loop runs either as a second-order filter, with one inner integrator that tracks frequency, or as a third-order filter, where a further integrator also tracks a drifting frequency, such as a spread-spectrum sweep. The gain shifts and the order select come from configuration registers outside the block. A data-slicing stage reads the average phase output.

Top module: `phaseTrackFilter`

## Requirements
- R1: While `rstN` is low, and on the first clock after it rises, `avgPhase` reads 0 and every integrator holds 0.
- R2: Lane i carries an unsigned PH_W-bit phase in `phaseVec[i*PH_W +: PH_W]`, worth value/2^PH_W UI. Its error is (phase − avgPhase) mod 2^PH_W, read as two's complement, so it lies in [−0.5, +0.5) UI. A difference of exactly half a UI counts as −0.5.
- R3: The errors of the valid lanes (`validVec[i]`=1) are summed into E. A lane whose valid bit is 0 adds nothing, whatever its phase.
- R4: The output accumulator has PH_W+FRAC_W bits. Each clock it adds ((E·2^FRAC_W) >>> `gainShift1`) + I2 and wraps modulo its width. `avgPhase` is its top PH_W bits.
- R5: The second integrator I2 adds ((E·2^FRAC_W) >>> `gainShift2`) each clock, plus the old I3 when third order is selected.
- R6: With `thirdOrder`=1, the third integrator I3 adds ((E·2^FRAC_W) >>> `gainShift3`) each clock.
- R7: With `thirdOrder`=0, I3 is cleared on the next clock and adds nothing to I2 in that same clock.
- R8: I2 and I3 saturate at the limits of a signed ACC_W-bit value instead of wrapping. The output accumulator may wrap.
- R9: A new input word moves `avgPhase` on the next rising clock edge and not before.
- R10: When no lane is valid, E is 0 and the average keeps advancing by I2 each clock. This lets the loop hold its frequency through gaps in the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseVec | input | LANES*PH_W | Per-lane crossing phase estimates |
| validVec | input | LANES | Per-lane valid flags |
| gainShift1 | input | SH_W | Right shift applied to the error for the output accumulator |
| gainShift2 | input | SH_W | Right shift applied to the error for I2 |
| gainShift3 | input | SH_W | Right shift applied to the error for I3 |
| thirdOrder | input | 1 | 1 selects the third-order loop, 0 the second-order loop |
| avgPhase | output | PH_W | Smoothed average crossing phase |

## Verification
Two events can fall in one clock: an inner integrator hitting its rail, and the output accumulator wrapping across the UI boundary. The bench sets all gain shifts to zero in third-order mode and holds every lane at almost +0.5 UI ahead of the average. This pins I2 and then I3 at their positive limits while the average laps the UI circle many times. Then it reverses the error. A reference model with explicit clamping and modulo arithmetic predicts every cycle. A wrap in an inner integrator, or a clamp on the output, would throw the average off within a few cycles.

// File: rtl/ptfPkg.sv
package ptfPkg;
  // Strobes that the control half hands to the datapath each clock.
  typedef struct packed {
    logic order3En;     // third integrator feeds the second
    logic clearInner3;  // third integrator is forced to zero
    logic anyValid;     // at least one lane carries an estimate
  } ptfCtrl_t;
endpackage

// File: rtl/ptfLaneErr.sv
module ptfLaneErr #(
  parameter int LANES = 4,
  parameter int PH_W  = 8,
  parameter int SUM_W = 11
) (
  input  logic [LANES*PH_W-1:0]    phaseVec,
  input  logic [LANES-1:0]         validVec,
  input  logic [PH_W-1:0]          avgPhase,
  output logic signed [SUM_W-1:0]  errSum
);
  logic signed [PH_W-1:0] laneErr [LANES];

  // Per-lane modulo-UI difference; reading the wrapped difference as
  // two's complement bounds it to [-half UI, +half UI).
  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    logic [PH_W-1:0] diff;
    assign diff        = phaseVec[gi*PH_W +: PH_W] - avgPhase;
    assign laneErr[gi] = validVec[gi] ? $signed(diff) : '0;
  end

  always_comb begin
    errSum = '0;
    for (int i = 0; i < LANES; i++) begin
      errSum = errSum + SUM_W'(laneErr[i]);
    end
  end
endmodule

// File: rtl/ptfSatInt.sv
module ptfSatInt #(
  parameter int ACC_W = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clear,
  input  logic signed [ACC_W-1:0]  addA,
  input  logic signed [ACC_W-1:0]  addB,
  output logic signed [ACC_W-1:0]  value
);
  localparam int WIDE_W = ACC_W + 2;
  localparam logic signed [WIDE_W-1:0] MAX_W = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] MIN_W = {3'b111, {(ACC_W-1){1'b0}}};

  logic signed [WIDE_W-1:0] wideSum;
  logic signed [ACC_W-1:0]  nextVal;

  assign wideSum = WIDE_W'(value) + WIDE_W'(addA) + WIDE_W'(addB);

  always_comb begin
    if (wideSum > MAX_W)      nextVal = MAX_W[ACC_W-1:0];
    else if (wideSum < MIN_W) nextVal = MIN_W[ACC_W-1:0];
    else                      nextVal = wideSum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      value <= '0;
    else if (clear) value <= '0;
    else            value <= nextVal;
  end

  // Non-negative increments never lower the value (a wrap would).
  assert_sat_up_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!clear && addA >= 0 && addB >= 0) |-> value >= $past(value));
  // Non-positive increments never raise the value.
  assert_sat_down_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!clear && addA <= 0 && addB <= 0) |-> value <= $past(value));
endmodule

// File: rtl/ptfControl.sv
module ptfControl #(
  parameter int LANES = 4
) (
  input  logic              thirdOrder,
  input  logic [LANES-1:0]  validVec,
  output ptfPkg::ptfCtrl_t  ctrl
);
  always_comb begin
    ctrl.order3En    = thirdOrder;
    ctrl.clearInner3 = !thirdOrder;
    ctrl.anyValid    = |validVec;
  end
endmodule

// File: rtl/ptfDatapath.sv
module ptfDatapath #(
  parameter int LANES  = 4,
  parameter int PH_W   = 8,
  parameter int FRAC_W = 8,
  parameter int ACC_W  = 24,
  parameter int SH_W   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ptfPkg::ptfCtrl_t       ctrl,
  input  logic [LANES*PH_W-1:0]  phaseVec,
  input  logic [LANES-1:0]       validVec,
  input  logic [SH_W-1:0]        gainShift1,
  input  logic [SH_W-1:0]        gainShift2,
  input  logic [SH_W-1:0]        gainShift3,
  output logic [PH_W-1:0]        avgPhase
);
  localparam int SUM_W    = PH_W + $clog2(LANES) + 1;
  localparam int ACC_PH_W = PH_W + FRAC_W;
  localparam int WIDE_W   = ACC_W + 2;

  logic [ACC_PH_W-1:0]       phaseAcc;
  logic signed [SUM_W-1:0]   errSum;
  logic signed [ACC_W-1:0]   errScaled, step1, step2, step3;
  logic signed [ACC_W-1:0]   int2, int3, int3Feed;
  logic signed [WIDE_W-1:0]  phaseStep;

  assign avgPhase = phaseAcc[ACC_PH_W-1 -: PH_W];

  ptfLaneErr #(.LANES(LANES), .PH_W(PH_W), .SUM_W(SUM_W)) u_laneErr (
    .phaseVec(phaseVec), .validVec(validVec),
    .avgPhase(avgPhase), .errSum(errSum)
  );

  // Align the error sum to the fixed-point grid of the integrators.
  assign errScaled = ACC_W'($signed({errSum, {FRAC_W{1'b0}}}));
  assign step1     = errScaled >>> gainShift1;
  assign step2     = errScaled >>> gainShift2;
  assign step3     = errScaled >>> gainShift3;

  ptfSatInt #(.ACC_W(ACC_W)) u_int3 (
    .clk(clk), .rstN(rstN), .clear(ctrl.clearInner3),
    .addA(step3), .addB('0), .value(int3)
  );

  assign int3Feed = ctrl.order3En ? int3 : '0;

  ptfSatInt #(.ACC_W(ACC_W)) u_int2 (
    .clk(clk), .rstN(rstN), .clear(1'b0),
    .addA(step2), .addB(int3Feed), .value(int2)
  );

  // Output accumulator wraps around the UI circle.
  assign phaseStep = WIDE_W'(step1) + WIDE_W'(int2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseAcc <= '0;
    else       phaseAcc <= phaseAcc + ACC_PH_W'(phaseStep);
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (phaseAcc == '0 && int2 == '0 && int3 == '0));
  assert_inner3_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.clearInner3) |-> int3 == '0);
  // No valid lane and no frequency term: the average must not move.
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ctrl.anyValid && int2 == '0) |-> phaseAcc == $past(phaseAcc));
  // With no valid lane the accumulator advances by exactly I2.
  assert_flywheel_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ctrl.anyValid) |-> phaseAcc == $past(phaseAcc + ACC_PH_W'(int2)));
endmodule

// File: rtl/phaseTrackFilter.sv
module phaseTrackFilter #(
  parameter int LANES  = 4,
  parameter int PH_W   = 8,
  parameter int FRAC_W = 8,
  parameter int ACC_W  = 24,
  parameter int SH_W   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES*PH_W-1:0]  phaseVec,
  input  logic [LANES-1:0]       validVec,
  input  logic [SH_W-1:0]        gainShift1,
  input  logic [SH_W-1:0]        gainShift2,
  input  logic [SH_W-1:0]        gainShift3,
  input  logic                   thirdOrder,
  output logic [PH_W-1:0]        avgPhase
);
  ptfPkg::ptfCtrl_t ctrl;

  ptfControl #(.LANES(LANES)) u_ctrl (
    .thirdOrder(thirdOrder), .validVec(validVec), .ctrl(ctrl)
  );

  ptfDatapath #(
    .LANES(LANES), .PH_W(PH_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W), .SH_W(SH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .phaseVec(phaseVec), .validVec(validVec),
    .gainShift1(gainShift1), .gainShift2(gainShift2), .gainShift3(gainShift3),
    .avgPhase(avgPhase)
  );
endmodule

// File: tb/tb_phaseTrackFilter.sv
module tb_phaseTrackFilter;
  localparam int LANES = 4;
  localparam int PH_W  = 8;
  localparam longint MAXI = (64'sd1 <<< 23) - 1;
  localparam longint MINI = -(64'sd1 <<< 23);

  typedef struct { longint expAvg; string tag; } item_t;

  logic clk = 0;
  logic rstN = 0;
  logic [LANES*PH_W-1:0] phaseVec = '0;
  logic [LANES-1:0] validVec = '0;
  logic [3:0] gainShift1 = 0, gainShift2 = 15, gainShift3 = 15;
  logic thirdOrder = 0;
  logic [PH_W-1:0] avgPhase;

  int nChecks = 0, nFail = 0;
  item_t sb[$];
  longint mAcc = 0, mI2 = 0, mI3 = 0;
  int pk1 = 0, pk2 = 15, pk3 = 15;
  bit pOrd = 0;

  always #5 clk = ~clk;

  phaseTrackFilter dut (
    .clk(clk), .rstN(rstN), .phaseVec(phaseVec), .validVec(validVec),
    .gainShift1(gainShift1), .gainShift2(gainShift2), .gainShift3(gainShift3),
    .thirdOrder(thirdOrder), .avgPhase(avgPhase)
  );

  function automatic longint sat(longint x);
    if (x > MAXI) return MAXI;
    if (x < MINI) return MINI;
    return x;
  endfunction

  function automatic longint mAvg();
    return (mAcc >> 8) & 255;
  endfunction

  task automatic check(longint act, longint exp, string tag);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: avgPhase actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setCfg(int k1, int k2, int k3, bit ord);
    pk1 = k1; pk2 = k2; pk3 = k3; pOrd = ord;
  endtask

  // Driver: applies one word at a falling edge and queues the model's result.
  task automatic step(logic [LANES*PH_W-1:0] ph, logic [LANES-1:0] v, string tag);
    longint sum, e, d, nI2, nI3, nAcc;
    @(negedge clk);
    phaseVec = ph; validVec = v;
    gainShift1 = 4'(pk1); gainShift2 = 4'(pk2); gainShift3 = 4'(pk3);
    thirdOrder = pOrd;
    sum = 0;
    for (int i = 0; i < LANES; i++) begin
      if (v[i]) begin
        d = (longint'(ph[i*PH_W +: PH_W]) - mAvg()) & 255;
        if (d >= 128) d -= 256;
        sum += d;
      end
    end
    e   = sum * 256;
    nI3 = pOrd ? sat(mI3 + (e >>> pk3)) : 0;
    nI2 = sat(mI2 + (e >>> pk2) + (pOrd ? mI3 : 0));
    nAcc = (mAcc + (e >>> pk1) + mI2) & 65535;
    mI3 = nI3; mI2 = nI2; mAcc = nAcc;
    sb.push_back('{mAvg(), tag});
  endtask

  // Builds a word with all four lanes at given offsets from the model average.
  function automatic logic [LANES*PH_W-1:0] offs(int o0, int o1, int o2, int o3);
    logic [LANES*PH_W-1:0] w;
    w[0 +: 8]  = 8'(mAvg() + o0);
    w[8 +: 8]  = 8'(mAvg() + o1);
    w[16 +: 8] = 8'(mAvg() + o2);
    w[24 +: 8] = 8'(mAvg() + o3);
    return w;
  endfunction

  // Monitor: compares each queued expectation shortly after the edge.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check(avgPhase, it.expAvg, it.tag);
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 0; validVec = '0;
    mAcc = 0; mI2 = 0; mI3 = 0;
    #1 check(avgPhase, 0, "R1 during reset");
    @(negedge clk);
    rstN = 1;
    #1 check(avgPhase, 0, "R1 after release");
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    doReset();

    // R2/R4: single lane, pure proportional path, positive error.
    setCfg(0, 15, 15, 0);
    step(offs(16, 0, 0, 0), 4'b0001, "R2 R4 positive error");
    // R9: output must not move before the edge.
    step(offs(-32, 0, 0, 0), 4'b0001, "R2 wrapped negative error");
    #1 check(avgPhase, 16, "R9 no change before edge");
    step(offs(0, 0, 0, 0), 4'b0000, "R9 settle");

    // R2: exact half-UI difference counts as -0.5 UI.
    doReset();
    setCfg(1, 15, 15, 0);
    step(offs(128, 0, 0, 0), 4'b0001, "R2 half UI is negative");
    step(offs(0, 0, 0, 0), 4'b0000, "R2 after half UI");

    // R3: lane sum, and invalid lanes ignored.
    doReset();
    setCfg(2, 15, 15, 0);
    step(offs(10, 20, -8, 40), 4'b1111, "R3 four lanes summed");
    step(offs(100, 90, -100, 70), 4'b0000, "R3 all invalid ignored");
    step(offs(12, 120, -120, 4), 4'b1001, "R3 mixed mask");
    step(offs(127, -128, 127, -128), 4'b0110, "R3 extreme lanes");

    // R5/R4: second-order loop chasing a frequency offset (ramp).
    doReset();
    setCfg(2, 6, 15, 0);
    for (int n = 0; n < 80; n++)
      step(offs(3 + n % 5, 3, 4, 2), 4'b1111, "R5 ramp second order");

    // R10: inputs vanish; average keeps moving at the learned rate.
    for (int n = 0; n < 20; n++)
      step(offs(50, 50, 50, 50), 4'b0000, "R10 flywheel");

    // R6: third-order loop with accelerating phase.
    doReset();
    setCfg(2, 5, 9, 1);
    for (int n = 0; n < 100; n++)
      step(offs(2 + n / 20, 2 + n / 25, 1, 3), 4'b1111, "R6 third order");

    // R7: drop to second order mid-run; I3 cleared and no longer fed.
    setCfg(2, 5, 9, 0);
    for (int n = 0; n < 30; n++)
      step(offs(-3, 2, -1, 0), 4'b1011, "R7 switch to second order");

    // R8: rails on I2 and I3 while the output laps the UI.
    doReset();
    setCfg(0, 0, 0, 1);
    for (int n = 0; n < 120; n++)
      step(offs(127, 127, 127, 127), 4'b1111, "R8 saturate positive");
    for (int n = 0; n < 150; n++)
      step(offs(-128, -128, -128, -128), 4'b1111, "R8 recover negative");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule